// File: doc/BRIEF.md
# Mode-Dispatching Packet Receiver

This block sits behind the host link and takes inbound packets as a stream of 32-bit words with valid, ready and last. Every transfer opens with a request packet. The request chooses one of two routes for the data packets that follow it, and it gives the number of those packets. On the bulk route the block removes each packet's header and sends only the payload words to a streaming output with backpressure. On the register route each packet carries one offset and one data word, and these become a single write strobe towards the control registers.

The low nibble of every header word is its type code. The transmitter on the other side uses the same codes. A header that does not fit the receiver's current state is reported with a one-cycle error pulse, and the whole packet is dropped. After the last word of the final packet that the request announced, the receiver returns to idle and waits for the next request. Every output is registered, so results appear one cycle after the input word is accepted.

Top module: `rxd_top`

## Requirements
- R1: After a synchronous reset, `mode` is 0 (idle) and `dma_valid`, `wr_en` and `err` are all low.
- R2: A header with type code 4'h1 in bits [3:0] is a request. It is accepted only in idle. Bit 4 picks the route (1 = bulk, 0 = register) and bits [15:8] give the number of data packets. From the cycle after the header is accepted, `mode` reads 2 for bulk or 1 for register. A count of 0 leaves `mode` at 0.
- R3: In bulk mode a packet starts with a header of type code 4'h3, and that header is not forwarded. Each later word of the packet appears on `dma_data` with `dma_valid` high one cycle after it is accepted. `dma_last` is set on the packet's final word.
- R4: In register mode a packet starts with a header of type code 4'h2 that holds the register offset in bits [31:16]. The packet's second word produces a one-cycle `wr_en` pulse one cycle after it is accepted, with that offset on `wr_addr` and the word on `wr_data`. Any further words of the packet are ignored.
- R5: While `dma_valid` is high and `dma_ready` is low, `dma_valid`, `dma_data` and `dma_last` hold their values.
- R6: Some headers are refused: an unknown type code, a data header while idle, a data header whose type belongs to the other route, and a request while a transfer is open. Each refused header gives a one-cycle `err` pulse in the cycle after it is accepted. The whole packet is then discarded and does not count towards the transfer.
- R7: In the cycle after the last word of the final counted data packet, `mode` returns to 0. A header-only data packet (header with last) counts as a packet.
- R8: `in_ready` equals `dma_ready` in every cycle, whatever the mode.
- R9: Words of a request packet after its header are ignored: they cause no output, no error and no change of `mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inbound word valid |
| in_ready | output | 1 | Inbound word accepted when high together with in_valid |
| in_data | input | 32 | Inbound word |
| in_last | input | 1 | Marks the final word of a packet |
| dma_valid | output | 1 | Bulk payload word valid |
| dma_ready | input | 1 | Bulk consumer ready |
| dma_data | output | 32 | Bulk payload word |
| dma_last | output | 1 | Final payload word of a packet |
| wr_en | output | 1 | Register write strobe, one cycle |
| wr_addr | output | 16 | Register offset |
| wr_data | output | 32 | Register write data |
| err | output | 1 | One-cycle pulse for a refused header |
| mode | output | 2 | 0 idle, 1 register route, 2 bulk route |

## Verification
Two events can fall on the same clock edge. The final payload beat of a bulk transfer can be handed off on the edge that returns `mode` to idle. In another case, a header that is refused is accepted on the edge where the consumer takes the previous beat, so `err` rises in the cycle `dma_valid` falls. The bench provokes both by sending packets back to back while `dma_ready` toggles at random, and by ending transfers with header-only packets. A behavioural model in the bench predicts every output in every cycle, and each cycle the design is compared with it, so a wrong order of these coinciding updates shows up as a mismatch on `mode`, `err` or the bulk port.

// File: rtl/rxd_pkg.sv
`timescale 1ns/1ps
package rxd_pkg;
  localparam logic [3:0] CODE_REQ = 4'h1;
  localparam logic [3:0] CODE_ORD = 4'h2;
  localparam logic [3:0] CODE_DMA = 4'h3;
  localparam int FLAG_POS = 4;
  localparam int CNT_LSB  = 8;

  typedef enum logic [1:0] {MODE_IDLE = 2'd0, MODE_ORD = 2'd1, MODE_DMA = 2'd2} mode_e;
  typedef enum logic [1:0] {CLS_REQ, CLS_ORD, CLS_DMA, CLS_BAD} cls_e;
  typedef enum logic [1:0] {K_DROP, K_ORD, K_DMA} kind_e;
endpackage

// File: rtl/rxd_hdr_class.sv
`timescale 1ns/1ps
module rxd_hdr_class
  import rxd_pkg::*;
(
  input  logic [3:0] code,
  output cls_e       cls
);
  always_comb begin
    unique case (code)
      CODE_REQ: cls = CLS_REQ;
      CODE_ORD: cls = CLS_ORD;
      CODE_DMA: cls = CLS_DMA;
      default:  cls = CLS_BAD;
    endcase
  end
endmodule

// File: rtl/rxd_ctrl.sv
`timescale 1ns/1ps
module rxd_ctrl
  import rxd_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic          last,
  input  logic [3:0]    code,
  input  logic          flag,
  input  logic [CW-1:0] cnt,
  input  logic [AW-1:0] ofs_in,
  output mode_e         mode,
  output logic          fwd,
  output logic          wr_fire,
  output logic [AW-1:0] ofs,
  output logic          bad_hdr
);
  cls_e          cls;
  logic          in_pkt;
  kind_e         kind_q;
  logic          got_q;
  logic [CW-1:0] left_q;
  logic          hdr, body, acc_req, acc_ord, acc_dma, pkt_end;

  rxd_hdr_class u_cls (.code(code), .cls(cls));

  always_comb begin
    hdr     = acc && !in_pkt;
    body    = acc && in_pkt;
    acc_req = hdr && (cls == CLS_REQ) && (mode == MODE_IDLE);
    acc_ord = hdr && (cls == CLS_ORD) && (mode == MODE_ORD);
    acc_dma = hdr && (cls == CLS_DMA) && (mode == MODE_DMA);
    bad_hdr = hdr && !(acc_req || acc_ord || acc_dma);
    fwd     = body && (kind_q == K_DMA);
    wr_fire = body && (kind_q == K_ORD) && !got_q;
    pkt_end = last && ((acc_ord || acc_dma) || (body && kind_q != K_DROP));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= MODE_IDLE;
      in_pkt <= 1'b0;
      kind_q <= K_DROP;
      got_q  <= 1'b0;
      left_q <= '0;
      ofs    <= '0;
    end else begin
      if (acc) in_pkt <= !last;
      if (hdr) begin
        kind_q <= acc_ord ? K_ORD : (acc_dma ? K_DMA : K_DROP);
        got_q  <= 1'b0;
        if (acc_ord) ofs <= ofs_in;
      end
      if (wr_fire) got_q <= 1'b1;
      if (acc_req && cnt != '0) begin
        mode   <= flag ? MODE_DMA : MODE_ORD;
        left_q <= cnt;
      end else if (pkt_end) begin
        if (left_q == CW'(1)) mode <= MODE_IDLE;
        left_q <= left_q - CW'(1);
      end
    end
  end
endmodule

// File: rtl/rxd_dma_out.sv
`timescale 1ns/1ps
module rxd_dma_out #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          lin,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
      last  <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= din;
      last  <= lin;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rxd_wr_out.sv
`timescale 1ns/1ps
module rxd_wr_out #(
  parameter int DW = 32,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [AW-1:0] ofs,
  input  logic [DW-1:0] din,
  input  logic          bad,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      err     <= 1'b0;
    end else begin
      wr_en <= fire;
      err   <= bad;
      if (fire) begin
        wr_addr <= ofs;
        wr_data <= din;
      end
    end
  end
endmodule

// File: rtl/rxd_top.sv
`timescale 1ns/1ps
module rxd_top
  import rxd_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          dma_valid,
  input  logic          dma_ready,
  output logic [DW-1:0] dma_data,
  output logic          dma_last,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          err,
  output logic [1:0]    mode
);
  localparam int OFS_LSB = DW - AW;

  mode_e         mode_s;
  logic          acc, fwd, wr_fire, bad_hdr;
  logic [AW-1:0] ofs;

  assign in_ready = dma_ready;
  assign acc      = in_valid && in_ready;
  assign mode     = mode_s;

  rxd_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .acc(acc), .last(in_last),
    .code(in_data[3:0]), .flag(in_data[FLAG_POS]),
    .cnt(in_data[CNT_LSB +: CW]), .ofs_in(in_data[OFS_LSB +: AW]),
    .mode(mode_s), .fwd(fwd), .wr_fire(wr_fire), .ofs(ofs), .bad_hdr(bad_hdr)
  );

  rxd_dma_out #(.DW(DW)) u_dma (
    .clk(clk), .rst(rst), .load(fwd), .din(in_data), .lin(in_last),
    .ready(dma_ready), .valid(dma_valid), .data(dma_data), .last(dma_last)
  );

  rxd_wr_out #(.DW(DW), .AW(AW)) u_wr (
    .clk(clk), .rst(rst), .fire(wr_fire), .ofs(ofs), .din(in_data), .bad(bad_hdr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .err(err)
  );

  // R5
  dma_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dma_valid && !dma_ready |=> dma_valid && $stable(dma_data) && $stable(dma_last));
  // R3
  dma_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_valid) |-> $past(in_valid && in_ready));
  // R4
  wr_src_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(in_valid && in_ready));
  // R6
  err_src_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(in_valid && in_ready) && !wr_en);
  // R2
  mode_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode) |-> $past(in_valid && in_ready));
endmodule

// File: tb/rxd_top_tb_top.sv
`timescale 1ns/1ps
module rxd_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        dma_ready = 1'b1;
  logic        in_ready, dma_valid, dma_last, wr_en, err;
  logic [31:0] dma_data, wr_data;
  logic [15:0] wr_addr;
  logic [1:0]  mode;

  int nchk = 0, nerr = 0;
  bit stall = 1'b0, done = 1'b0;

  // reference model state
  int m_mode, m_left, m_kind;
  bit m_inpkt, m_got;
  logic [15:0] m_ofs;
  bit e_dv, e_dl, e_wr, e_err;
  logic [31:0] e_dd, e_wd;
  logic [15:0] e_wa;

  always #4 clk = ~clk;

  rxd_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_data(dma_data),
    .dma_last(dma_last), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .err(err), .mode(mode)
  );

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  task pkt_done();
    m_left--;
    if (m_left == 0) m_mode = 0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_left = 0; m_kind = 0; m_inpkt = 0; m_got = 0; m_ofs = '0;
      e_dv = 0; e_dl = 0; e_wr = 0; e_err = 0; e_dd = '0; e_wd = '0; e_wa = '0;
    end else begin
      e_err = 0; e_wr = 0;
      if (e_dv && dma_ready) e_dv = 0;
      if (in_valid && dma_ready) begin
        if (!m_inpkt) begin
          m_kind = 0; m_got = 0;
          if (in_data[3:0] == 4'h1 && m_mode == 0) begin
            if (in_data[15:8] != 0) begin
              m_mode = in_data[4] ? 2 : 1;
              m_left = int'(in_data[15:8]);
            end
          end else if (in_data[3:0] == 4'h2 && m_mode == 1) begin
            m_kind = 1; m_ofs = in_data[31:16];
            if (in_last) pkt_done();
          end else if (in_data[3:0] == 4'h3 && m_mode == 2) begin
            m_kind = 2;
            if (in_last) pkt_done();
          end else begin
            e_err = 1;
          end
        end else if (m_kind == 2) begin
          e_dv = 1; e_dd = in_data; e_dl = in_last;
          if (in_last) pkt_done();
        end else if (m_kind == 1) begin
          if (!m_got) begin
            e_wr = 1; e_wa = m_ofs; e_wd = in_data; m_got = 1;
          end
          if (in_last) pkt_done();
        end
        m_inpkt = !in_last;
      end
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      check(mode == 2'd0 && !dma_valid && !wr_en && !err, "R1 reset outputs",
            {mode, dma_valid, wr_en, err}, 0);
    end else if (!done) begin
      check(in_ready === dma_ready, "R8 in_ready", in_ready, dma_ready);
      check(mode === 2'(m_mode), "R2 R7 R9 mode", mode, m_mode);
      check(err === e_err, "R6 err", err, e_err);
      check(dma_valid === e_dv, "R3 R5 dma_valid", dma_valid, e_dv);
      if (e_dv)
        check(dma_data === e_dd && dma_last === e_dl, "R3 R5 dma_data/last",
              {dma_last, dma_data}, {e_dl, e_dd});
      check(wr_en === e_wr, "R4 wr_en", wr_en, e_wr);
      if (e_wr)
        check(wr_addr === e_wa && wr_data === e_wd, "R4 wr_addr/wr_data",
              {wr_addr, wr_data}, {e_wa, e_wd});
    end
  end

  always begin
    @(posedge clk); #2;
    dma_ready = stall ? (($urandom % 4) != 0) : 1'b1;
  end

  task send(input logic [31:0] d, input logic l);
    in_valid = 1'b1; in_data = d; in_last = l;
    do @(posedge clk); while (!in_ready);
    #2;
  endtask

  task gap();
    in_valid = 1'b0;
    @(posedge clk); #2;
  endtask

  task finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    // R9: register request for 2 packets with two trailing words
    send(32'h0000_0201, 1'b0); send(32'h1111_1111, 1'b0); send(32'h0000_0003, 1'b1); gap();
    check(mode == 2'd1 && !err, "R9 trailing request words ignored", mode, 1);
    // R4: register packets, one with an extra word
    send(32'h0040_0002, 1'b0); send(32'hDEAD_BEEF, 1'b1);
    send(32'h0044_0002, 1'b0); send(32'h1234_5678, 1'b0); send(32'hFFFF_FFFF, 1'b1); gap();
    check(mode == 2'd0, "R7 idle after final register packet", mode, 0);
    // R6: data while idle, unknown code, back to back
    send(32'h0000_0003, 1'b1); send(32'h0000_0007, 1'b1); send(32'hABCD_0002, 1'b0);
    send(32'h5555_5555, 1'b1); gap();
    // R2: count 0 stays idle
    send(32'h0000_0011, 1'b1); gap();
    check(mode == 2'd0, "R2 zero count keeps idle", mode, 0);
    // R3 R5: bulk transfer under stalls, with wrong-route and nested request
    stall = 1'b1;
    send(32'h0000_0211, 1'b1);
    send(32'h0000_0003, 1'b0);
    for (int i = 0; i < 4; i++) send(32'hA000_0000 + i, i == 3);
    send(32'h0010_0002, 1'b0); send(32'h0, 1'b1);
    send(32'h0000_0111, 1'b1);
    send(32'h0000_0003, 1'b1);
    send(32'h0000_0009, 1'b1); gap();
    check(mode == 2'd0, "R7 idle after header-only final packet", mode, 0);
    // random traffic
    for (int n = 0; n < 400; n++) begin
      int sel = $urandom % 4;
      int len;
      case (sel)
        0: send({16'h0, 8'($urandom % 3), 3'b0, 1'($urandom), 4'h1}, 1'b1);
        1: begin
          len = 1 + $urandom % 3;
          send({16'($urandom), 12'h0, 4'h2}, len == 1);
          for (int k = 1; k < len; k++) send($urandom, k == len - 1);
        end
        2: begin
          len = 1 + $urandom % 5;
          send(32'h0000_0003, len == 1);
          for (int k = 1; k < len; k++) send($urandom, k == len - 1);
        end
        default: send({28'($urandom), 4'(4 + $urandom % 12)}, 1'b1);
      endcase
      if ($urandom % 3 == 0) gap();
    end
    stall = 1'b0;
    gap(); gap(); gap();
    done = 1'b1;
    finish_run();
  end
endmodule